// File: doc/BRIEF.md
# Multiport Priority Memory Arbiter

This block decides which of up to six request ports may start the next cycle of one memory unit. Each port supplies a normal request line, a high-priority line, an inhibit control and a reserve control. The arbiter issues a one-cycle grant to at most one port. It issues a grant only when the memory core reports that it is not busy. After a grant it waits for the core to signal completion before it arbitrates again.

Ports are numbered 1 to 6, with port 1 the most favoured. Bit 0 of every per-port vector belongs to port 1 and bit 5 to port 6. A high-priority line lifts its port above every normal request. Among high-priority requests the lowest-numbered port still wins. A port that is granted while its reserve input is high gains exclusive use of the memory. Only that port can be granted until it makes an access with reserve low. While nothing is pending, the selection register rests on port 1. A configuration code sets how many ports are present.

Top module: `mport_arbiter`

## Requirements
- R1: Synchronous active-high reset clears `grant` to zero, returns `sel_port` to 0 (port 1), releases any reservation and leaves the arbiter idle.
- R2: When the arbiter is idle, the core is not busy and no high-priority request is eligible, the lowest-numbered eligible port with `req` high is granted. Example: requests on ports 2 and 4 grant port 2 (`grant` = 6'b000010).
- R3: An eligible port with `hipri` high beats every normal request. When several high-priority requests are eligible, the lowest-numbered one wins. A port counts as requesting if either `req` or `hipri` is high.
- R4: `grant` is a one-hot, one-cycle pulse. It rises on the clock edge after a cycle in which the arbiter was idle, `mem_busy` was low and an eligible request existed. While `mem_busy` is high no grant is issued.
- R5: After a grant, no further grant is issued until `mem_done` has been seen high. Arbitration can resume on the edge after that cycle.
- R6: A port whose `inhibit` bit is high is never granted, whatever its `req`, `hipri` or `reserve` inputs.
- R7: `cfg_ports` gives the port count: 2'b00 means 2 ports, 2'b01 means 4 ports, and 2'b10 or 2'b11 means 6 ports. Ports above the count behave as permanently inhibited.
- R8: A grant to a port whose `reserve` is high establishes a reservation for that port. While the reservation is held, only that port can be granted, even against high-priority requests from other ports.
- R9: A grant to the reservation owner with its `reserve` low releases the reservation. A grant with `reserve` high keeps or moves the ownership to the granted port.
- R10: `sel_port` (0 to 5, meaning port 1 to 6) takes the index of each granted port. On any idle edge with no eligible request it returns to 0, pre-selecting port 1. It holds its value while an access is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ports | input | 2 | Port-count code (00: 2, 01: 4, 1x: 6) |
| req | input | 6 | Normal request per port, bit 0 = port 1 |
| hipri | input | 6 | High-priority request per port |
| inhibit | input | 6 | Per-port inhibit |
| reserve | input | 6 | Per-port reserve control, sampled at grant |
| mem_busy | input | 1 | Memory core is busy; no grant may issue |
| mem_done | input | 1 | Memory core finished the granted access |
| grant | output | 6 | One-hot, one-cycle grant pulse |
| sel_port | output | 3 | Currently selected port index (0 = port 1) |

## Verification
The reservation filter and the high-priority promotion can act on the same arbitration edge. The bench provokes this by raising a high-priority request on a lower-numbered port while another port holds the reservation. It then repeats the case with the owner also requesting, and again after the owner has released. Inhibit and the port-count limit are also combined with high-priority lines in the same cycle. A behavioural model in the bench predicts `grant` and `sel_port` for every edge, and the design's outputs are compared against it after each edge.

// File: rtl/mpa_pkg.sv
package mpa_pkg;

    localparam int MAX_PORTS = 6;
    localparam int IDX_W     = $clog2(MAX_PORTS);

    typedef logic [MAX_PORTS-1:0] port_vec_t;
    typedef logic [IDX_W-1:0]     port_idx_t;

    typedef enum logic {
        ARB_IDLE = 1'b0,
        ARB_WAIT = 1'b1
    } arb_state_t;

    typedef struct packed {
        logic      found;
        port_idx_t idx;
    } pick_t;

    // Lowest set bit wins (port 1 is bit 0).
    function automatic pick_t pick_lowest(port_vec_t v);
        pick_t r;
        r.found = 1'b0;
        r.idx   = '0;
        for (int i = MAX_PORTS - 1; i >= 0; i--) begin
            if (v[i]) begin
                r.found = 1'b1;
                r.idx   = port_idx_t'(i);
            end
        end
        return r;
    endfunction

    function automatic int count_from_code(logic [1:0] code);
        int n;
        case (code)
            2'b00:   n = 2;
            2'b01:   n = 4;
            default: n = 6;
        endcase
        if (n > MAX_PORTS) n = MAX_PORTS;
        return n;
    endfunction

    function automatic port_vec_t present_mask(logic [1:0] code);
        port_vec_t m;
        int n;
        n = count_from_code(code);
        for (int i = 0; i < MAX_PORTS; i++) begin
            m[i] = (i < n);
        end
        return m;
    endfunction

    function automatic port_vec_t idx_to_vec(port_idx_t i);
        port_vec_t v;
        v    = '0;
        v[i] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/mpa_eligibility.sv
module mpa_eligibility
    import mpa_pkg::*;
(
    input  logic [1:0] cfg_ports,
    input  port_vec_t  inhibit,
    input  logic       res_held,
    input  port_idx_t  res_owner,
    output port_vec_t  eligible
);
    port_vec_t present;
    port_vec_t res_filter;

    always_comb begin
        present    = present_mask(cfg_ports);
        res_filter = res_held ? idx_to_vec(res_owner) : '1;
        eligible   = present & ~inhibit & res_filter;
    end

endmodule

// File: rtl/mpa_pick.sv
module mpa_pick
    import mpa_pkg::*;
(
    input  port_vec_t cand,
    output pick_t     result
);
    always_comb begin
        result = pick_lowest(cand);
    end

endmodule

// File: rtl/mpa_reserve.sv
module mpa_reserve
    import mpa_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      fire,
    input  port_idx_t winner,
    input  logic      winner_reserve,
    output logic      held,
    output port_idx_t owner
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held  <= 1'b0;
            owner <= '0;
        end else if (fire) begin
            if (winner_reserve) begin
                held  <= 1'b1;
                owner <= winner;
            end else if (held && owner == winner) begin
                held  <= 1'b0;
            end
        end
    end

    // R9: the reservation state moves only on a granted access
    assert_res_stable_R9: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable({held, owner}))
        else $error("reservation changed without a grant");

    // R8: a grant with reserve high always leaves the reservation held
    assert_res_taken_R8: assert property (@(posedge clk) disable iff (rst)
        (fire && winner_reserve) |=> held)
        else $error("reservation not taken");

endmodule

// File: rtl/mport_arbiter.sv
module mport_arbiter
    import mpa_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           cfg_ports,
    input  logic [MAX_PORTS-1:0] req,
    input  logic [MAX_PORTS-1:0] hipri,
    input  logic [MAX_PORTS-1:0] inhibit,
    input  logic [MAX_PORTS-1:0] reserve,
    input  logic                 mem_busy,
    input  logic                 mem_done,
    output logic [MAX_PORTS-1:0] grant,
    output logic [IDX_W-1:0]     sel_port
);
    arb_state_t state_q;
    port_vec_t  grant_q;
    port_idx_t  sel_q;
    port_vec_t  eligible;
    pick_t      hi_pick;
    pick_t      lo_pick;
    pick_t      win;
    logic       res_held;
    port_idx_t  res_owner;
    logic       fire;

    mpa_eligibility u_elig (
        .cfg_ports (cfg_ports),
        .inhibit   (inhibit),
        .res_held  (res_held),
        .res_owner (res_owner),
        .eligible  (eligible)
    );

    mpa_pick u_pick_hi (
        .cand   (hipri & eligible),
        .result (hi_pick)
    );

    mpa_pick u_pick_lo (
        .cand   ((req | hipri) & eligible),
        .result (lo_pick)
    );

    always_comb begin
        win  = hi_pick.found ? hi_pick : lo_pick;
        fire = (state_q == ARB_IDLE) && !mem_busy && win.found;
    end

    mpa_reserve u_res (
        .clk            (clk),
        .rst            (rst),
        .fire           (fire),
        .winner         (win.idx),
        .winner_reserve (reserve[win.idx]),
        .held           (res_held),
        .owner          (res_owner)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ARB_IDLE;
            grant_q <= '0;
            sel_q   <= '0;
        end else begin
            grant_q <= '0;
            case (state_q)
                ARB_IDLE: begin
                    if (fire) begin
                        grant_q <= idx_to_vec(win.idx);
                        sel_q   <= win.idx;
                        state_q <= ARB_WAIT;
                    end else if (!win.found) begin
                        sel_q   <= '0;
                    end
                end
                ARB_WAIT: begin
                    if (mem_done) state_q <= ARB_IDLE;
                end
                default: state_q <= ARB_IDLE;
            endcase
        end
    end

    assign grant    = grant_q;
    assign sel_port = sel_q;

    // R4: grant is one-hot and is issued only after a not-busy cycle
    assert_grant_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant))
        else $error("grant not one-hot");

    assert_grant_not_busy_R4: assert property (@(posedge clk) disable iff (rst)
        (|grant) |-> !$past(mem_busy))
        else $error("grant while core busy");

    // R5: no grant in the cycle following a grant
    assert_no_back_to_back_R5: assert property (@(posedge clk) disable iff (rst)
        (|grant) |=> !(|grant))
        else $error("back-to-back grant");

    // R6: an inhibited port is never granted
    assert_no_inhibited_R6: assert property (@(posedge clk) disable iff (rst)
        (|grant) |-> !(|(grant & $past(inhibit))))
        else $error("inhibited port granted");

    // R8: while a reservation is held, only its owner is granted
    assert_reserved_owner_R8: assert property (@(posedge clk) disable iff (rst)
        ((|grant) && $past(res_held)) |-> (grant == idx_to_vec($past(res_owner))))
        else $error("grant to non-owner under reservation");

    // R10: a grant and the selection register agree
    assert_sel_matches_R10: assert property (@(posedge clk) disable iff (rst)
        (|grant) |-> (grant == idx_to_vec(sel_port)))
        else $error("selection disagrees with grant");

endmodule

// File: tb/mport_arbiter_tb.sv
module mport_arbiter_tb;

    localparam int NP = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    cfg_ports = 2'b10;
    logic [NP-1:0] req = '0, hipri = '0, inhibit = '0, reserve = '0;
    logic          mem_busy = 1'b0, mem_done = 1'b0;
    logic [NP-1:0] grant;
    logic [2:0]    sel_port;

    int checks = 0;
    int fails  = 0;

    // behavioural reference state
    int m_busy_acc = 0;   // 1 while an access is outstanding
    int m_res      = 0;
    int m_owner    = 0;
    int m_sel      = 0;

    always #4 clk = ~clk;

    mport_arbiter u_dut (
        .clk(clk), .rst(rst), .cfg_ports(cfg_ports),
        .req(req), .hipri(hipri), .inhibit(inhibit), .reserve(reserve),
        .mem_busy(mem_busy), .mem_done(mem_done),
        .grant(grant), .sel_port(sel_port)
    );

    function automatic int port_limit(logic [1:0] c);
        if (c == 2'b00) return 2;
        if (c == 2'b01) return 4;
        return 6;
    endfunction

    task automatic step(input logic r, input logic [NP-1:0] rq, input logic [NP-1:0] hp,
                        input logic [NP-1:0] inh, input logic [NP-1:0] rs,
                        input logic bsy, input logic dn, input string tag);
        logic [NP-1:0] exp_g;
        int w;
        bit ok_port;
        @(negedge clk);
        rst = r; req = rq; hipri = hp; inhibit = inh; reserve = rs;
        mem_busy = bsy; mem_done = dn;
        exp_g = '0;
        if (r) begin
            m_busy_acc = 0; m_res = 0; m_owner = 0; m_sel = 0;
        end else if (m_busy_acc == 0) begin
            w = -1;
            for (int i = 0; i < NP; i++) begin
                ok_port = (i < port_limit(cfg_ports)) && !inh[i] && !(m_res == 1 && m_owner != i);
                if (w < 0 && ok_port && hp[i]) w = i;
            end
            if (w < 0) begin
                for (int i = 0; i < NP; i++) begin
                    ok_port = (i < port_limit(cfg_ports)) && !inh[i] && !(m_res == 1 && m_owner != i);
                    if (w < 0 && ok_port && (rq[i] || hp[i])) w = i;
                end
            end
            if (w < 0) begin
                m_sel = 0;
            end else if (!bsy) begin
                exp_g[w]   = 1'b1;
                m_sel      = w;
                m_busy_acc = 1;
                if (rs[w]) begin
                    m_res = 1; m_owner = w;
                end else if (m_res == 1 && m_owner == w) begin
                    m_res = 0;
                end
            end
        end else if (dn) begin
            m_busy_acc = 0;
        end
        @(posedge clk);
        #1;
        checks++;
        if (grant !== exp_g || sel_port !== 3'(m_sel)) begin
            fails++;
            $display("FAIL %s: grant=%b sel=%0d expected grant=%b sel=%0d",
                     tag, grant, sel_port, exp_g, m_sel);
        end
    endtask

    task automatic idle(input int n, input string tag);
        for (int k = 0; k < n; k++) step(1'b0, '0, '0, '0, '0, 1'b0, 1'b0, tag);
    endtask

    task automatic finish_acc(input string tag);
        step(1'b0, '0, '0, '0, '0, 1'b0, 1'b1, tag);
    endtask

    initial begin : watchdog
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        // R1: reset state
        step(1'b1, 6'b111111, 6'b000001, '0, '0, 1'b0, 1'b0, "R1");
        step(1'b1, 6'b000000, '0, '0, '0, 1'b0, 1'b0, "R1");
        // R10: quiescent, port 1 preselected
        idle(2, "R10");
        // R2: ports 2 and 4 -> port 2
        step(1'b0, 6'b001010, '0, '0, '0, 1'b0, 1'b0, "R2");
        step(1'b0, 6'b001010, '0, '0, '0, 1'b0, 1'b0, "R5");
        step(1'b0, 6'b001010, '0, '0, '0, 1'b0, 1'b0, "R5");
        step(1'b0, 6'b001010, '0, '0, '0, 1'b0, 1'b1, "R5");
        step(1'b0, 6'b001000, '0, '0, '0, 1'b0, 1'b0, "R2");
        finish_acc("R5");
        idle(1, "R10");
        // R4: busy core blocks grants
        step(1'b0, 6'b100100, '0, '0, '0, 1'b1, 1'b0, "R4");
        step(1'b0, 6'b100100, '0, '0, '0, 1'b1, 1'b0, "R4");
        step(1'b0, 6'b100100, '0, '0, '0, 1'b0, 1'b0, "R4");
        step(1'b0, 6'b100100, '0, '0, '0, 1'b0, 1'b0, "R4");
        finish_acc("R4");
        // R3: high priority beats lower-numbered normal; lowest hi wins
        step(1'b0, 6'b000001, 6'b101000, '0, '0, 1'b0, 1'b0, "R3");
        finish_acc("R3");
        step(1'b0, 6'b000001, 6'b100000, '0, '0, 1'b0, 1'b0, "R3");
        finish_acc("R3");
        // R6: inhibit
        step(1'b0, 6'b000101, 6'b000001, 6'b000001, '0, 1'b0, 1'b0, "R6");
        finish_acc("R6");
        step(1'b0, '0, 6'b000010, 6'b000010, 6'b000010, 1'b0, 1'b0, "R6");
        // R7: port count
        cfg_ports = 2'b00;
        step(1'b0, 6'b010000, 6'b100000, '0, '0, 1'b0, 1'b0, "R7");
        step(1'b0, 6'b001100, '0, '0, '0, 1'b0, 1'b0, "R7");
        cfg_ports = 2'b01;
        step(1'b0, 6'b011000, '0, '0, '0, 1'b0, 1'b0, "R7");
        finish_acc("R7");
        cfg_ports = 2'b11;
        step(1'b0, 6'b100000, '0, '0, '0, 1'b0, 1'b0, "R7");
        finish_acc("R7");
        // R8: port 3 reserves; others shut out even with high priority
        step(1'b0, 6'b000100, '0, '0, 6'b000100, 1'b0, 1'b0, "R8");
        finish_acc("R8");
        step(1'b0, 6'b000001, 6'b000011, '0, '0, 1'b0, 1'b0, "R8");
        step(1'b0, 6'b000101, 6'b000001, '0, 6'b000100, 1'b0, 1'b0, "R8");
        finish_acc("R8");
        // R9: owner accesses without reserve -> released
        step(1'b0, 6'b000100, '0, '0, '0, 1'b0, 1'b0, "R9");
        finish_acc("R9");
        step(1'b0, 6'b000001, '0, '0, '0, 1'b0, 1'b0, "R9");
        finish_acc("R9");
        // R9: ownership moves on reserve grant by a new port after release
        step(1'b0, 6'b010000, '0, '0, 6'b010000, 1'b0, 1'b0, "R9");
        finish_acc("R9");
        step(1'b0, 6'b010010, 6'b000010, '0, 6'b000000, 1'b0, 1'b0, "R9");
        finish_acc("R9");
        step(1'b0, 6'b000010, '0, '0, '0, 1'b0, 1'b0, "R9");
        finish_acc("R9");
        // R1: reset drops a reservation
        step(1'b0, 6'b000100, '0, '0, 6'b000100, 1'b0, 1'b0, "R8");
        step(1'b1, '0, '0, '0, '0, 1'b0, 1'b0, "R1");
        step(1'b0, 6'b000001, '0, '0, '0, 1'b0, 1'b0, "R1");
        finish_acc("R1");
        idle(2, "R10");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule